// File: doc/BRIEF.md
# Single-Operand Bit Manipulation Unit

This unit carries out the one-source bit operations of an integer datapath: three shift-by-one variants that feed the shifted-out bit into the carry flag, sign extension from a byte or a half-word, a leading-zero count, and byte and half-word swaps. It also carries out three two-operand pattern compares: a byte-match finder, an equality test and an inequality test. Bits are labelled 0 (most significant) to 31 (least significant). In the vectors below, label 0 is index 31 and label 31 is index 0.

Each operation enters as one beat on a valid/ready input stream. The beat carries the two operands, the current carry flag and a four-bit operation code. One output register stage holds the result word, the new carry value and a carry write enable. The output is offered on a valid/ready output stream. When the consumer holds `out_ready` low, the result stays where it is and `in_ready` drops, so back-pressure reaches the producer in the same cycle. A stage that is empty, or that is being drained in the same cycle, accepts a new beat.

Top module: `bitmanip_unit`

## Requirements
- R1: A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result is presented with `out_valid` high from the next edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_carry` and `out_carry_we` hold their values.
- R2: Code 0 (arithmetic shift right by one) gives `in_a` shifted right by one with the sign bit (index 31) replicated. The new carry is index 0 of `in_a` and `out_carry_we` is 1.
- R3: Code 1 (shift right through carry) gives `in_a` shifted right by one with `in_carry` placed at index 31. The new carry is index 0 of `in_a` and `out_carry_we` is 1.
- R4: Code 2 (logical shift right by one) gives `in_a` shifted right by one with 0 placed at index 31. The new carry is index 0 of `in_a` and `out_carry_we` is 1.
- R5: Code 3 sign-extends the low byte of `in_a` (indices 7..0) to 32 bits. Code 4 sign-extends the low half-word (indices 15..0).
- R6: Code 5 returns the number of zero bits above the highest set bit of `in_a`. An all-zero input returns 32.
- R7: Code 6 reverses the order of the four bytes of `in_a`. Code 7 exchanges its upper and lower 16-bit halves.
- R8: Code 8 compares the bytes of `in_a` and `in_b` lane by lane and returns the 1-based position of the first equal lane. The scan starts at the most significant byte, so indices 31..24 are position 1 and indices 7..0 are position 4. It returns 0 if no lane matches.
- R9: Code 9 returns 1 when `in_a` equals `in_b` and 0 otherwise. Code 10 returns the inverse.
- R10: For every code other than 0, 1 and 2, `out_carry_we` is 0 and `out_carry` repeats `in_carry`.
- R11: Codes 11 to 15 produce a result of 0.
- R12: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand (pattern compares only) |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result word |
| out_carry | output | 1 | New carry value |
| out_carry_we | output | 1 | Carry flag should be written |

## Verification
The assertions assume the consumer obeys the output handshake. They also assume that the fields of an input beat are meaningful only in a cycle where `in_valid` is high. The range and carry-enable checks therefore fire only on accepted beats. The stimulus keeps `in_op` within its four-bit field. It changes inputs only between edges, and it keeps a beat's fields steady until `in_ready` takes it. `out_ready` is toggled at random so that stalls of several cycles occur, and the hold rule is exercised under them.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SHR_ARITH = 4'd0,
    OP_SHR_CARRY = 4'd1,
    OP_SHR_LOGIC = 4'd2,
    OP_SEXT_BYTE = 4'd3,
    OP_SEXT_HALF = 4'd4,
    OP_LZ_COUNT  = 4'd5,
    OP_SWAP_BYTE = 4'd6,
    OP_SWAP_HALF = 4'd7,
    OP_PAT_FIND  = 4'd8,
    OP_PAT_EQ    = 4'd9,
    OP_PAT_NE    = 4'd10
  } bmu_op_e;

  function automatic logic op_is_shift(input logic [OP_W-1:0] op);
    return (op == OP_SHR_ARITH) || (op == OP_SHR_CARRY) || (op == OP_SHR_LOGIC);
  endfunction
endpackage

// File: rtl/bmu_shift.sv
module bmu_shift
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              hit
);
  logic top_fill;

  always_comb begin
    unique case (op)
      OP_SHR_ARITH: top_fill = a[DATA_W-1];
      OP_SHR_CARRY: top_fill = cin;
      default:      top_fill = 1'b0;
    endcase
    res  = {top_fill, a[DATA_W-1:1]};
    cout = a[0];
    hit  = op_is_shift(op);
  end
endmodule

// File: rtl/bmu_unary.sv
module bmu_unary
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] res,
  output logic              hit
);
  localparam int NBYTES = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] swapped_bytes;
  logic [DATA_W-1:0] swapped_halves;
  logic [DATA_W-1:0] ext_byte;
  logic [DATA_W-1:0] ext_half;
  logic [CNT_W-1:0]  lz_cnt;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign swapped_bytes[g*8 +: 8] = a[(NBYTES-1-g)*8 +: 8];
  end

  assign swapped_halves = {a[HALF_W-1:0], a[DATA_W-1:HALF_W]};
  assign ext_byte       = {{(DATA_W-8){a[7]}}, a[7:0]};
  assign ext_half       = {{(DATA_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};

  always_comb begin
    lz_cnt = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (a[i]) lz_cnt = CNT_W'(DATA_W - 1 - i);
    end
  end

  always_comb begin
    hit = 1'b1;
    unique case (op)
      OP_SEXT_BYTE: res = ext_byte;
      OP_SEXT_HALF: res = ext_half;
      OP_LZ_COUNT:  res = DATA_W'(lz_cnt);
      OP_SWAP_BYTE: res = swapped_bytes;
      OP_SWAP_HALF: res = swapped_halves;
      default: begin
        res = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bmu_pcmp.sv
module bmu_pcmp
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              hit
);
  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = $clog2(NBYTES + 1);

  logic [NBYTES-1:0] lane_eq;
  logic [IDX_W-1:0]  first_pos;
  logic              words_eq;

  for (genvar k = 0; k < NBYTES; k++) begin : g_cmp
    assign lane_eq[k] = (a[DATA_W-1-8*k -: 8] == b[DATA_W-1-8*k -: 8]);
  end

  assign words_eq = (a == b);

  always_comb begin
    first_pos = '0;
    for (int k = NBYTES - 1; k >= 0; k--) begin
      if (lane_eq[k]) first_pos = IDX_W'(k + 1);
    end
  end

  always_comb begin
    hit = 1'b1;
    unique case (op)
      OP_PAT_FIND: res = DATA_W'(first_pos);
      OP_PAT_EQ:   res = DATA_W'(words_eq);
      OP_PAT_NE:   res = DATA_W'(!words_eq);
      default: begin
        res = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_carry_we
);
  logic [DATA_W-1:0] sh_res, un_res, pc_res, nxt_res;
  logic              sh_cout, sh_hit, un_hit, pc_hit;
  logic              nxt_carry, nxt_we;
  logic              in_fire;

  bmu_shift #(.DATA_W(DATA_W)) u_shift (
    .op(in_op), .a(in_a), .cin(in_carry), .res(sh_res), .cout(sh_cout), .hit(sh_hit)
  );

  bmu_unary #(.DATA_W(DATA_W)) u_unary (
    .op(in_op), .a(in_a), .res(un_res), .hit(un_hit)
  );

  bmu_pcmp #(.DATA_W(DATA_W)) u_pcmp (
    .op(in_op), .a(in_a), .b(in_b), .res(pc_res), .hit(pc_hit)
  );

  always_comb begin
    if (sh_hit)      nxt_res = sh_res;
    else if (un_hit) nxt_res = un_res;
    else if (pc_hit) nxt_res = pc_res;
    else             nxt_res = '0;
    nxt_carry = sh_hit ? sh_cout : in_carry;
    nxt_we    = sh_hit;
  end

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_carry    <= 1'b0;
      out_carry_we <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= nxt_res;
        out_carry    <= nxt_carry;
        out_carry_we <= nxt_we;
      end
    end
  end

  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_carry) && $stable(out_carry_we)));

  a_r10_no_carry_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !op_is_shift(in_op)) |=> (!out_carry_we && out_carry == $past(in_carry)));

  a_r2_shift_carry_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && op_is_shift(in_op)) |=> (out_carry_we && out_carry == $past(in_a[0])));

  a_r11_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_op > 4'd10) |=> (out_result == '0));

  a_r8_find_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_op == OP_PAT_FIND) |=> (out_result <= DATA_W'(DATA_W / 8)));

  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_op == OP_LZ_COUNT) |=> (out_result <= DATA_W'(DATA_W)));
endmodule

// File: tb/sim_bitmanip_unit.sv
module sim_bitmanip_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_carry;
  logic        out_carry_we;

  int vectors = 0;
  int fails   = 0;
  bit run_done = 1'b0;

  always #2 clk = ~clk;

  bitmanip_unit u0 (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_a, .in_b, .in_carry,
    .out_valid, .out_ready, .out_result, .out_carry, .out_carry_we
  );

  typedef struct {
    logic [31:0] res;
    logic        c;
    logic        we;
    string       tag;
  } exp_t;

  exp_t expq[$];

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic c);
    exp_t e;
    int n;
    e.tag = tag_of(op);
    e.c = c;
    e.we = 1'b0;
    e.res = 32'd0;
    case (op)
      4'd0: begin e.res = $signed(a) >>> 1; e.c = a[0]; e.we = 1'b1; end
      4'd1: begin e.res = (a >> 1) | (32'(c) << 31); e.c = a[0]; e.we = 1'b1; end
      4'd2: begin e.res = a >> 1; e.c = a[0]; e.we = 1'b1; end
      4'd3: e.res = 32'($signed(a[7:0]));
      4'd4: e.res = 32'($signed(a[15:0]));
      4'd5: begin
        n = 0;
        while (n < 32 && a[31-n] == 1'b0) n++;
        e.res = 32'(n);
      end
      4'd6: e.res = {a[7:0], a[15:8], a[23:16], a[31:24]};
      4'd7: e.res = {a[15:0], a[31:16]};
      4'd8: begin
        for (int p = 4; p >= 1; p--)
          if (((a >> (32 - 8*p)) & 32'hFF) == ((b >> (32 - 8*p)) & 32'hFF)) e.res = 32'(p);
      end
      4'd9:  e.res = (a == b) ? 32'd1 : 32'd0;
      4'd10: e.res = (a != b) ? 32'd1 : 32'd0;
      default: e.res = 32'd0;
    endcase
    return e;
  endfunction

  logic        prev_stall = 1'b0;
  logic [31:0] prev_res;
  logic        prev_c, prev_we;
  int          cycles = 0;

  always @(negedge clk) begin
    if (rst_n && !run_done) begin
      cycles++;
      if (prev_stall) begin
        vectors++;
        if (!out_valid || out_result !== prev_res || out_carry !== prev_c || out_carry_we !== prev_we) begin
          fails++;
          $display("FAIL R1 stall hold: got v=%0b %h/%0b/%0b expected v=1 %h/%0b/%0b",
                   out_valid, out_result, out_carry, out_carry_we, prev_res, prev_c, prev_we);
        end
      end
      vectors++;
      if (in_ready !== (!out_valid || out_ready)) begin
        fails++;
        $display("FAIL R1 in_ready: got %0b expected %0b", in_ready, !out_valid || out_ready);
      end
      if (out_valid && out_ready) begin
        vectors++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected output: got %h expected none", out_result);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (out_result !== e.res || out_carry !== e.c || out_carry_we !== e.we) begin
            fails++;
            $display("FAIL %s/R10: got %h c=%0b we=%0b expected %h c=%0b we=%0b",
                     e.tag, out_result, out_carry, out_carry_we, e.res, e.c, e.we);
          end
        end
      end
      if (in_valid && in_ready) expq.push_back(model(in_op, in_a, in_b, in_carry));
      prev_stall = out_valid && !out_ready;
      prev_res = out_result;
      prev_c = out_carry;
      prev_we = out_carry_we;
    end
  end

  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic c);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_carry = c;
    do begin
      @(posedge clk);
    end while (!in_ready);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin : drive
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R12 reset: got out_valid=%0b expected 0", out_valid);
    end
    rst_n = 1'b1;
    out_ready = 1'b1;
    // R2 R3 R4 shifts, carry in both states
    for (int c = 0; c < 2; c++) begin
      send(4'd0, 32'h8000_0001, 0, c[0]);
      send(4'd0, 32'h4000_0002, 0, c[0]);
      send(4'd1, 32'h0000_0003, 0, c[0]);
      send(4'd1, 32'hFFFF_FFFE, 0, c[0]);
      send(4'd2, 32'h8000_0001, 0, c[0]);
    end
    // R5 sign extension
    send(4'd3, 32'h1234_5680, 0, 1'b1);
    send(4'd3, 32'hFFFF_FF7F, 0, 1'b0);
    send(4'd4, 32'h0000_8001, 0, 1'b0);
    send(4'd4, 32'hFFFF_7FFF, 0, 1'b1);
    // R6 leading zeros including all-zero and top bit set
    send(4'd5, 32'h0000_0000, 0, 1'b0);
    send(4'd5, 32'h8000_0000, 0, 1'b0);
    send(4'd5, 32'h0000_0001, 0, 1'b1);
    send(4'd5, 32'h0001_F000, 0, 1'b0);
    // R7 swaps
    send(4'd6, 32'h1234_5678, 0, 1'b0);
    send(4'd7, 32'h1234_5678, 0, 1'b1);
    // R8 byte find each position and none
    send(4'd8, 32'h1122_3344, 32'h1122_3344, 1'b0);
    send(4'd8, 32'h1122_3344, 32'h0022_0044, 1'b0);
    send(4'd8, 32'h1122_3344, 32'h0000_3300, 1'b0);
    send(4'd8, 32'h1122_3344, 32'h0000_0044, 1'b0);
    send(4'd8, 32'h1122_3344, 32'h5566_7788, 1'b1);
    // R9 equality
    send(4'd9, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0);
    send(4'd9, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 1'b0);
    send(4'd10, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1);
    send(4'd10, 32'h0, 32'h1, 1'b1);
    // R11 unknown codes, R10 carry passthrough
    for (int op = 11; op < 16; op++) send(4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    // back-to-back random traffic with back-pressure (R1)
    fork
      begin
        for (int i = 0; i < 3000; i++) begin
          @(posedge clk); #1;
          out_ready = ($urandom_range(0, 2) != 0);
        end
      end
      begin
        for (int i = 0; i < 2000; i++) begin
          logic [31:0] ra, rb;
          ra = $urandom;
          rb = ($urandom_range(0, 1) != 0) ? ra ^ (32'hFF << (8 * $urandom_range(0, 3))) : $urandom;
          if ($urandom_range(0, 7) == 0) ra = ra >> $urandom_range(0, 31);
          send(4'($urandom_range(0, 15)), ra, rb, 1'($urandom_range(0, 1)));
        end
      end
    join
    out_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    vectors++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R1 drain: got %0d pending expected 0", expq.size());
    end
    run_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!run_done) begin
      run_done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule